// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is the purely combinational arithmetic and logic unit of a 32-bit integer pipeline. Each evaluation takes two operands, a 5-bit shift count from an instruction field, and an operation code. It returns a 32-bit result, a flag that is set when the result is all zeros, and a flag for signed overflow. The operations are addition and subtraction, with or without overflow detection, signed and unsigned less-than compares, the four bitwise functions, left and right shifts, and placement of an upper half-word.

All shifts act on operand B. The shift count comes from one of two places. Constant shifts take it from `shamt_imm`. Variable shifts take it from the low 5 bits of operand A, and the upper bits of A play no part. The block has no state. The execute stage registers its outputs.

Top module: `int_alu32`

## Requirements
- R1: Op code 0 (checked add) and op code 1 (unchecked add) return A+B modulo 2^32.
- R2: Op code 2 (checked subtract) and op code 3 (unchecked subtract) return A-B modulo 2^32.
- R3: `ovf` is 1 only for op codes 0 and 2, and only when the true signed result does not fit in 32 bits. For every other op code `ovf` is 0, including op codes 1 and 3.
- R4: Op code 4 returns 1 when A < B as two's-complement numbers, and 0 otherwise.
- R5: Op code 5 returns 1 when A < B as unsigned numbers, and 0 otherwise.
- R6: Op codes 6, 7, 8 and 9 return A AND B, A OR B, A XOR B and NOT(A OR B).
- R7: Op codes 10, 11 and 12 shift B by `shamt_imm` (0 to 31 positions). Code 10 shifts left, code 11 shifts right logically and code 12 shifts right arithmetically.
- R8: Op codes 13, 14 and 15 shift B left, logically right and arithmetically right by A[4:0]. Bits A[31:5] have no effect.
- R9: Arithmetic right shifts (codes 12 and 15) fill vacated bits with B[31]. Logical right shifts (codes 11 and 14) fill them with 0. Left shifts fill with 0.
- R10: Op code 16 returns B[15:0] in bits 31:16 and zeros in bits 15:0.
- R11: `zero` is 1 exactly when `result` is 0.
- R12: Op codes 17 to 31 return a result of 0 with `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; supplies the variable shift count |
| opnd_b | input | 32 | Second operand; the value that is shifted or placed |
| shamt_imm | input | 5 | Constant shift count from the instruction |
| op_sel | input | 5 | Operation code (see requirements) |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of checked add or subtract |

## Verification
Signed overflow and the compare results near the sign boundary are the hardest cases to reach. Uniform random operands rarely land where the two operands' signs and the result's sign give overflow, or where A and B differ by one across zero. The stimulus therefore draws about half of its operands from a small pool of edge values (0, 1, all ones, the most positive and most negative numbers) and adds directed vectors for each overflow direction. Variable shifts use operands A with nonzero upper bits, so that any use of A[31:5] would show in the result.

// File: rtl/int_alu_pkg.sv
// Package: shared widths and operation codes for the integer ALU.
// Assumes: the operation code is 5 bits; codes above OP_UPPER are unused.
package int_alu_pkg;
    localparam int DATA_W = 32;
    localparam int OPC_W  = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDU  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBU  = 5'd3,
        OP_SLT   = 5'd4,
        OP_SLTU  = 5'd5,
        OP_AND   = 5'd6,
        OP_OR    = 5'd7,
        OP_XOR   = 5'd8,
        OP_NOR   = 5'd9,
        OP_SLL   = 5'd10,
        OP_SRL   = 5'd11,
        OP_SRA   = 5'd12,
        OP_SLLV  = 5'd13,
        OP_SRLV  = 5'd14,
        OP_SRAV  = 5'd15,
        OP_UPPER = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;
endpackage

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// One adder that performs both A+B and A-B. It also yields the raw signed
// overflow and the signed and unsigned less-than results of A-B.
// Assumes: the compare outputs are meaningful only when sub_en is 1.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         sub_en,
    output logic [W-1:0] sum_out,
    output logic         ovf_raw,
    output logic         lt_signed,
    output logic         lt_unsigned
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide_sum;

    // Add or subtract through a single carry chain, then derive the flags.
    always_comb begin
        b_eff       = sub_en ? ~b_in : b_in;
        wide_sum    = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
        sum_out     = wide_sum[W-1:0];
        ovf_raw     = (a_in[MSB] == b_eff[MSB]) && (sum_out[MSB] != a_in[MSB]);
        lt_unsigned = ~wide_sum[W];
        lt_signed   = (a_in[MSB] ^ b_in[MSB]) ? a_in[MSB] : sum_out[MSB];

        // R3: an overflowing add needs like signs, an overflowing subtract unlike signs
        if (ovf_raw) begin
            assert_ovf_signs_R3: assert (sub_en ? (a_in[MSB] != b_in[MSB])
                                                : (a_in[MSB] == b_in[MSB]))
                else $error("overflow with impossible operand signs");
        end
        if (sub_en) begin
            assert_ult_R5: assert (lt_unsigned == (a_in < b_in))
                else $error("borrow disagrees with unsigned order");
            assert_slt_R4: assert (lt_signed == ($signed(a_in) < $signed(b_in)))
                else $error("signed compare disagrees with signed order");
        end
    end
endmodule

// File: rtl/alu_bitwise.sv
// Module: alu_bitwise
// Bitwise AND, OR, XOR and NOR of two operands, chosen by a 2-bit function code.
// Assumes: nothing beyond equal operand widths.
module alu_bitwise #(
    parameter int W = 32
) (
    input  logic [W-1:0]            a_in,
    input  logic [W-1:0]            b_in,
    input  int_alu_pkg::logic_fn_e  fn,
    output logic [W-1:0]            res_out
);
    import int_alu_pkg::*;

    logic [W-1:0] v_and, v_or, v_xor;

    // Compute each function, then select one.
    always_comb begin
        v_and = a_in & b_in;
        v_or  = a_in | b_in;
        v_xor = a_in ^ b_in;
        unique case (fn)
            LG_AND:  res_out = v_and;
            LG_OR:   res_out = v_or;
            LG_XOR:  res_out = v_xor;
            default: res_out = ~v_or;
        endcase
        // R6: the AND and XOR terms together cover exactly the OR term
        assert_bitwise_cover_R6: assert ((v_and | v_xor) == v_or)
            else $error("bitwise terms inconsistent");
    end
endmodule

// File: rtl/alu_barrel.sv
// Module: alu_barrel
// Logarithmic barrel shifter. Stage i moves the value by 2**i positions
// when count bit i is set. Left shifts fill with zero. Right shifts fill
// with the sign bit when arith is 1 and with zero otherwise.
// Assumes: W is a power of two, and the count is log2(W) bits wide.
module alu_barrel #(
    parameter int W = 32,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  val_in,
    input  logic [CW-1:0] count,
    input  logic          go_left,
    input  logic          arith,
    output logic [W-1:0]  res_out
);
    localparam int MSB = W - 1;

    logic [W-1:0] lchain [CW+1];
    logic [W-1:0] rchain [CW+1];
    logic         fill_bit;

    assign fill_bit  = arith & val_in[MSB];
    assign lchain[0] = val_in;
    assign rchain[0] = val_in;

    // One conditional shift stage per count bit, for both directions.
    for (genvar i = 0; i < CW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign lchain[i+1] = count[i] ? {lchain[i][W-1-STEP:0], {STEP{1'b0}}}
                                      : lchain[i];
        assign rchain[i+1] = count[i] ? {{STEP{fill_bit}}, rchain[i][W-1:STEP]}
                                      : rchain[i];
    end

    // Pick the direction and check the shifter invariants.
    always_comb begin
        res_out = go_left ? lchain[CW] : rchain[CW];
        // R7: a zero count leaves the operand unchanged
        if (count == '0) begin
            assert_shift_zero_R7: assert (res_out == val_in)
                else $error("zero-count shift altered the value");
        end
        // R9: an arithmetic right shift keeps the sign bit
        if (!go_left && arith) begin
            assert_sra_sign_R9: assert (res_out[MSB] == val_in[MSB])
                else $error("arithmetic shift lost the sign");
        end
        // R9: a logical right shift by a nonzero count clears the top bit
        if (!go_left && !arith && count != '0) begin
            assert_srl_fill_R9: assert (res_out[MSB] == 1'b0)
                else $error("logical shift filled with one");
        end
    end
endmodule

// File: rtl/int_alu32.sv
// Module: int_alu32 (top)
// Combinational integer ALU. It decodes the operation code, drives the
// adder, the bitwise unit and the shifter, and selects the result. The
// zero and overflow flags are formed here.
// Assumes: the caller registers the outputs, and unused codes give zero.
module int_alu32 #(
    parameter int W = int_alu_pkg::DATA_W,
    parameter int OW = int_alu_pkg::OPC_W
) (
    input  logic [W-1:0]          opnd_a,
    input  logic [W-1:0]          opnd_b,
    input  logic [$clog2(W)-1:0]  shamt_imm,
    input  logic [OW-1:0]         op_sel,
    output logic [W-1:0]          result,
    output logic                  zero,
    output logic                  ovf
);
    import int_alu_pkg::*;

    localparam int CW   = $clog2(W);
    localparam int HALF = W / 2;

    logic [W-1:0]  as_sum, lg_res, sh_res;
    logic          as_ovf, as_lt_s, as_lt_u;
    logic          sub_en, sh_left, sh_arith, sh_var;
    logic [CW-1:0] sh_count;
    logic_fn_e     lg_fn;

    // Decode the operation code into controls for the sub-units.
    always_comb begin
        sub_en   = (op_sel == OP_SUB) || (op_sel == OP_SUBU) ||
                   (op_sel == OP_SLT) || (op_sel == OP_SLTU);
        sh_left  = (op_sel == OP_SLL) || (op_sel == OP_SLLV);
        sh_arith = (op_sel == OP_SRA) || (op_sel == OP_SRAV);
        sh_var   = (op_sel == OP_SLLV) || (op_sel == OP_SRLV) || (op_sel == OP_SRAV);
        sh_count = sh_var ? opnd_a[CW-1:0] : shamt_imm;
        case (op_sel)
            OP_OR:   lg_fn = LG_OR;
            OP_XOR:  lg_fn = LG_XOR;
            OP_NOR:  lg_fn = LG_NOR;
            default: lg_fn = LG_AND;
        endcase
    end

    alu_addsub #(.W(W)) u_addsub (
        .a_in        (opnd_a),
        .b_in        (opnd_b),
        .sub_en      (sub_en),
        .sum_out     (as_sum),
        .ovf_raw     (as_ovf),
        .lt_signed   (as_lt_s),
        .lt_unsigned (as_lt_u)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .a_in    (opnd_a),
        .b_in    (opnd_b),
        .fn      (lg_fn),
        .res_out (lg_res)
    );

    alu_barrel #(.W(W), .CW(CW)) u_barrel (
        .val_in  (opnd_b),
        .count   (sh_count),
        .go_left (sh_left),
        .arith   (sh_arith),
        .res_out (sh_res)
    );

    // Select the result and the overflow flag by operation class.
    always_comb begin
        result = '0;
        ovf    = 1'b0;
        case (op_sel)
            OP_ADD, OP_SUB:    begin result = as_sum; ovf = as_ovf; end
            OP_ADDU, OP_SUBU:  result = as_sum;
            OP_SLT:            result = {{(W-1){1'b0}}, as_lt_s};
            OP_SLTU:           result = {{(W-1){1'b0}}, as_lt_u};
            OP_AND, OP_OR,
            OP_XOR, OP_NOR:    result = lg_res;
            OP_SLL, OP_SRL, OP_SRA,
            OP_SLLV, OP_SRLV,
            OP_SRAV:           result = sh_res;
            OP_UPPER:          result = {opnd_b[HALF-1:0], {HALF{1'b0}}};
            default:           result = '0;
        endcase
    end

    // Zero flag over the final result.
    assign zero = ~|result;

    // Guard the flags against the operation code.
    always_comb begin
        // R3: overflow only ever reported for the checked add and subtract
        if (ovf) begin
            assert_no_overflow_R3: assert ((op_sel == OP_ADD) || (op_sel == OP_SUB))
                else $error("overflow raised for an unchecked operation");
        end
        // R4 R5: compares yield only 0 or 1
        if ((op_sel == OP_SLT) || (op_sel == OP_SLTU)) begin
            assert_cmp_bool_R4: assert (result[W-1:1] == '0)
                else $error("compare result wider than one bit");
        end
        // R12: unused codes give a zero result
        if (op_sel > OP_UPPER) begin
            assert_unused_zero_R12: assert (zero)
                else $error("unused code gave a nonzero result");
        end
    end
endmodule

// File: tb/int_alu32_test.sv
module int_alu32_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a, opnd_b, result;
    logic [4:0]  shamt_imm, op_sel;
    logic        zero, ovf;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    int_alu32 uut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt_imm(shamt_imm),
        .op_sel(op_sel), .result(result), .zero(zero), .ovf(ovf)
    );

    // Expected result from the requirements.
    function automatic logic [31:0] exp_result(input logic [4:0] op, input logic [31:0] a,
                                               input logic [31:0] b, input logic [4:0] sh);
        logic [4:0] va = a[4:0];
        case (op)
            5'd0, 5'd1: return a + b;
            5'd2, 5'd3: return a - b;
            5'd4:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            5'd5:  return (a < b) ? 32'd1 : 32'd0;
            5'd6:  return a & b;
            5'd7:  return a | b;
            5'd8:  return a ^ b;
            5'd9:  return ~(a | b);
            5'd10: return b << sh;
            5'd11: return b >> sh;
            5'd12: return $unsigned($signed(b) >>> sh);
            5'd13: return b << va;
            5'd14: return b >> va;
            5'd15: return $unsigned($signed(b) >>> va);
            5'd16: return {b[15:0], 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    // Expected overflow flag, from a 64-bit signed reference.
    function automatic logic exp_ovf(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint r;
        if (op == 5'd0) r = sa + sb;
        else if (op == 5'd2) r = sa - sb;
        else return 1'b0;
        return (r > 64'sd2147483647) || (r < -64'sd2147483648);
    endfunction

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1: return "R1";
            5'd2, 5'd3: return "R2";
            5'd4: return "R4";
            5'd5: return "R5";
            5'd6, 5'd7, 5'd8, 5'd9: return "R6";
            5'd10, 5'd11, 5'd12: return "R7";
            5'd13, 5'd14, 5'd15: return "R8";
            5'd16: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h sh=%0d: actual %h expected %h",
                     tag, op_sel, opnd_a, opnd_b, shamt_imm, act, exp);
        end
    endtask

    // Drive one vector after a rising edge and check it at the falling edge.
    task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, input string extra);
        logic [31:0] er;
        @(posedge clk);
        #1;
        op_sel = op; opnd_a = a; opnd_b = b; shamt_imm = sh;
        @(negedge clk);
        er = exp_result(op, a, b, sh);
        check(extra.len() != 0 ? extra : req_of(op), result, er);
        check("R3", {31'h0, ovf}, {31'h0, exp_ovf(op, a, b)});
        check("R11", {31'h0, zero}, {31'h0, (er == 32'h0)});
    endtask

    function automatic logic [31:0] pick_operand();
        logic [31:0] pool [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                  32'h8000_0000, 32'h8000_0001};
        if ($urandom_range(1, 0) == 0) return pool[$urandom_range(5, 0)];
        return $urandom();
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        opnd_a = '0; opnd_b = '0; shamt_imm = '0; op_sel = 5'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: zero inputs with the add code give a zero result (R11)
        check("R11", {30'h0, zero, ovf}, {30'h0, 1'b1, 1'b0});
        check("R1", result, 32'h0);

        // Directed corner cases
        apply(5'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, "R3");          // positive overflow
        apply(5'd1, 32'h7FFF_FFFF, 32'h1, 5'd0, "R3");          // unchecked: no flag
        apply(5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0, "R3");  // negative overflow
        apply(5'd2, 32'h8000_0000, 32'h1, 5'd0, "R3");          // sub overflow
        apply(5'd3, 32'h8000_0000, 32'h1, 5'd0, "R3");
        apply(5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R3");
        apply(5'd0, 32'h5, 32'hFFFF_FFFB, 5'd0, "R11");         // zero result
        apply(5'd4, 32'hFFFF_FFFF, 32'h1, 5'd0, "R4");
        apply(5'd5, 32'hFFFF_FFFF, 32'h1, 5'd0, "R5");
        apply(5'd4, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R4");
        apply(5'd5, 32'h1234, 32'h1234, 5'd0, "R5");
        apply(5'd12, 32'h0, 32'h8000_0000, 5'd31, "R9");
        apply(5'd11, 32'h0, 32'h8000_0000, 5'd31, "R9");
        apply(5'd15, 32'hFFFF_FFE4, 32'h8765_4321, 5'd0, "R9");
        apply(5'd14, 32'hABCD_EF25, 32'hF000_0000, 5'd0, "R8");
        apply(5'd13, 32'hFFFF_FFE1, 32'h8000_0001, 5'd17, "R8");
        apply(5'd10, 32'h0, 32'hFFFF_FFFF, 5'd31, "R7");
        apply(5'd16, 32'hFFFF_FFFF, 32'h1234_ABCD, 5'd9, "R10");
        apply(5'd9, 32'h0, 32'h0, 5'd0, "R6");
        apply(5'd20, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, "R12");
        apply(5'd31, 32'h7FFF_FFFF, 32'h1, 5'd3, "R12");

        // Constrained random: every code including unused ones
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] op = (i < 2700) ? 5'($urandom_range(16, 0)) : 5'($urandom_range(31, 17));
            apply(op, pick_operand(), pick_operand(), 5'($urandom_range(31, 0)), "");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        finished = 1'b1;
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule